// File: doc/BRIEF.md
# Process-Tagged Address Translation Cache with Table Refill

This block translates a virtual address into a physical address for the process that issues it. It keeps a small fully associative store of recent translations. Every stored translation carries the process ID that owns it, so translations from several processes can sit side by side without one process ever reaching another's frames.

A request presents a virtual address and a process ID. The upper bits are the page number and the lower bits are the offset. When a stored entry matches, the block answers on the next cycle and does not touch memory. When nothing matches, a small table walker reads one page-table word through a memory read port. If that word is marked present, the walker installs the mapping and the block replays the lookup, which then hits. If the word is not marked present, the block returns a fault. A flush input clears every stored entry at once, for example on a process switch.

Top module: `pid_xlat_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `mem_req_valid` is 0, and no entry is valid, so the first request of any page misses.
- R2: The page number is `req_vaddr[31:12]` and the offset is `req_vaddr[11:0]`. A successful response carries `rsp_paddr = {frame[19:0], offset}`, with the offset passed through unchanged.
- R3: A request hits only when an entry is valid and matches both the page number and the process ID. A hit sets `rsp_valid` in the cycle after acceptance, issues no memory read, and never matches more than one entry.
- R4: A miss issues one read at address `pt_base + page_number*4`, using `pt_base` as it stood when the request was accepted. `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen. Read data may arrive any number of cycles later on `mem_rsp_valid`.
- R5: A page-table word uses bit 31 as the present flag and bits [19:0] as the frame number, and bits [30:20] are ignored. When a present word arrives, the mapping is installed, the lookup is replayed the next cycle and must hit, and `rsp_valid` rises two cycles after the `mem_rsp_valid` cycle.
- R6: A word with bit 31 clear installs nothing. The block answers in the cycle after `mem_rsp_valid` with `rsp_fault` = 1 and `rsp_paddr` = 0, and a later request for the same page misses again.
- R7: Only one translation is in flight. `req_ready` stays 0 from the miss until the response is delivered.
- R8: While `flush` is high, `req_ready` is 0. One flush cycle invalidates every entry, so every previously stored page misses afterwards.
- R9: A flush raised during a refill, including in the same cycle as the read data, is applied. The refilled entry is still installed, so the response is the correct translation and the same page hits afterwards.
- R10: The victim is the lowest-numbered invalid entry when one exists. When all 8 entries are valid, a round-robin pointer picks the victim. The pointer starts at entry 0 after reset, advances by one after each eviction of a valid entry, and is not moved by a flush.
- R11: The same page number requested under a different process ID misses and gets its own entry, and both mappings then hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| pt_base | input | 32 | Page-table base address |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_pid | input | 8 | Requesting process ID |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Page not present |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Page-table word address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Page-table word |

## Verification
The assertions rely on several things about the inputs. The memory returns exactly one `mem_rsp_valid` for each accepted read, and never one while no read is outstanding. `flush` stays low during reset. The response side is always ready for the one-cycle strobe. The bench meets these conditions with a single responder process that waits for each read, applies random-looking ready and data latencies, and returns one word per read. It drives flush only from the directed steps, or from inside the responder when it is aligned with a read. It drives requests only while `req_ready` is high, and it changes `pt_base` only between requests.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_REPLAY} xlat_state_e;
  typedef enum logic [1:0] {WK_IDLE, WK_REQ, WK_WAIT} walk_state_e;
endpackage

// File: rtl/tlb_tag_store.sv
module tlb_tag_store #(
  parameter int NUM_ENT = 8,
  parameter int VPN_W   = 20,
  parameter int PID_W   = 8,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [PID_W-1:0]   lk_pid,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PID_W-1:0]   wr_pid,
  input  logic [PFN_W-1:0]   wr_pfn,
  output logic               hit,
  output logic [PFN_W-1:0]   hit_pfn,
  output logic [NUM_ENT-1:0] valid_vec
);
  logic [NUM_ENT-1:0] match;
  logic [PFN_W-1:0]   pfn_q [NUM_ENT];

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    logic             vld_q, vld_d;
    logic [VPN_W-1:0] vpn_q;
    logic [PID_W-1:0] pid_q;
    logic             sel;

    assign sel = wr_en && (wr_idx == IDX_W'(i));

    always_comb begin
      vld_d = vld_q;
      if (flush) vld_d = 1'b0;
      if (sel)   vld_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        vpn_q    <= wr_vpn;
        pid_q    <= wr_pid;
        pfn_q[i] <= wr_pfn;
      end
    end

    assign match[i]     = vld_q && (vpn_q == lk_vpn) && (pid_q == lk_pid);
    assign valid_vec[i] = vld_q;
  end

  always_comb begin
    hit_pfn = '0;
    for (int k = 0; k < NUM_ENT; k++) begin
      if (match[k]) hit_pfn = hit_pfn | pfn_q[k];
    end
  end

  assign hit = |match;

  // R3: a key lives in at most one entry
  assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R8: a flush cycle without an install leaves nothing valid
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !wr_en) |=> (valid_vec == '0));

  // R9: an install that meets a flush survives it
  assert_install_survives_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && wr_en) |=> ($countones(valid_vec) == 1));
endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
  parameter int NUM_ENT = 8,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ENT-1:0] valid_vec,
  input  logic               install,
  output logic [IDX_W-1:0]   victim
);
  logic [IDX_W-1:0] rr_q, rr_d;
  logic [IDX_W-1:0] free_idx;
  logic             have_free;

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int k = NUM_ENT - 1; k >= 0; k--) begin
      if (!valid_vec[k]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(k);
      end
    end
  end

  assign victim = have_free ? free_idx : rr_q;

  always_comb begin
    rr_d = rr_q;
    if (install && !have_free) begin
      rr_d = (rr_q == IDX_W'(NUM_ENT - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

  // R10: a free slot is never passed over for a valid one
  assert_free_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_vec != '1) |-> !valid_vec[victim]);
endmodule

// File: rtl/tlb_table_walker.sv
module tlb_table_walker
  import tlb_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int MEM_AW = 32,
  parameter int MEM_DW = 32,
  parameter int PRES_B = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VPN_W-1:0]  vpn,
  input  logic [MEM_AW-1:0] base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [MEM_AW-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [MEM_DW-1:0] mem_rsp_data,
  output logic              done,
  output logic              present,
  output logic [PFN_W-1:0]  pfn
);
  walk_state_e st_q, st_d;
  logic [MEM_AW-1:0] addr_q;
  logic              addr_en;
  logic [MEM_DW-1:0] unused_pte_bits;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      WK_IDLE: if (start)         st_d = WK_REQ;
      WK_REQ:  if (mem_req_ready) st_d = WK_WAIT;
      WK_WAIT: if (mem_rsp_valid) st_d = WK_IDLE;
      default:                    st_d = WK_IDLE;
    endcase
  end

  assign addr_en = (st_q == WK_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WK_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= base + (MEM_AW'(vpn) << 2);
  end

  assign mem_req_valid   = (st_q == WK_REQ);
  assign mem_req_addr    = addr_q;
  assign done            = (st_q == WK_WAIT) && mem_rsp_valid;
  assign present         = mem_rsp_data[PRES_B];
  assign pfn             = mem_rsp_data[PFN_W-1:0];
  assign unused_pte_bits = mem_rsp_data;

  // R4: an offered read holds until taken
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

// File: rtl/pid_xlat_cache.sv
module pid_xlat_cache
  import tlb_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PID_W   = 8,
  parameter int PFN_W   = 20,
  parameter int NUM_ENT = 8,
  parameter int MEM_AW  = 32,
  parameter int MEM_DW  = 32,
  parameter int PRES_B  = 31,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PA_W   = PFN_W + OFF_W,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [MEM_AW-1:0] pt_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [PID_W-1:0]  req_pid,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [MEM_AW-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [MEM_DW-1:0] mem_rsp_data
);
  xlat_state_e st_q, st_d;

  logic [VPN_W-1:0] q_vpn;
  logic [OFF_W-1:0] q_off;
  logic [PID_W-1:0] q_pid;
  logic             cap_en;

  logic [VPN_W-1:0] lk_vpn;
  logic [PID_W-1:0] lk_pid;
  logic [OFF_W-1:0] lk_off;
  logic             hit;
  logic [PFN_W-1:0] hit_pfn;
  logic [NUM_ENT-1:0] valid_vec;
  logic [IDX_W-1:0] victim;

  logic             accept, walk_start;
  logic             walk_done, walk_present;
  logic [PFN_W-1:0] walk_pfn;
  logic             install;

  logic             rv_d, rf_d;
  logic [PA_W-1:0]  rp_d;

  assign req_ready = (st_q == ST_IDLE) && !flush;
  assign accept    = req_valid && req_ready;

  assign lk_vpn = (st_q == ST_IDLE) ? req_vaddr[VA_W-1:OFF_W] : q_vpn;
  assign lk_pid = (st_q == ST_IDLE) ? req_pid : q_pid;
  assign lk_off = (st_q == ST_IDLE) ? req_vaddr[OFF_W-1:0] : q_off;

  assign walk_start = accept && !hit;
  assign install    = walk_done && walk_present;
  assign cap_en     = accept;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (walk_start) st_d = ST_WALK;
      ST_WALK:   if (walk_done)  st_d = walk_present ? ST_REPLAY : ST_IDLE;
      ST_REPLAY:                 st_d = ST_IDLE;
      default:                   st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    rv_d = 1'b0;
    rf_d = 1'b0;
    rp_d = '0;
    if (st_q == ST_IDLE && accept && hit) begin
      rv_d = 1'b1;
      rp_d = {hit_pfn, lk_off};
    end else if (st_q == ST_WALK && walk_done && !walk_present) begin
      rv_d = 1'b1;
      rf_d = 1'b1;
    end else if (st_q == ST_REPLAY) begin
      rv_d = 1'b1;
      rp_d = {hit_pfn, lk_off};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      st_q      <= st_d;
      rsp_valid <= rv_d;
      rsp_fault <= rf_d;
      rsp_paddr <= rp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vpn <= '0;
      q_off <= '0;
      q_pid <= '0;
    end else if (cap_en) begin
      q_vpn <= req_vaddr[VA_W-1:OFF_W];
      q_off <= req_vaddr[OFF_W-1:0];
      q_pid <= req_pid;
    end
  end

  tlb_tag_store #(
    .NUM_ENT (NUM_ENT),
    .VPN_W   (VPN_W),
    .PID_W   (PID_W),
    .PFN_W   (PFN_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .lk_vpn    (lk_vpn),
    .lk_pid    (lk_pid),
    .wr_en     (install),
    .wr_idx    (victim),
    .wr_vpn    (q_vpn),
    .wr_pid    (q_pid),
    .wr_pfn    (walk_pfn),
    .hit       (hit),
    .hit_pfn   (hit_pfn),
    .valid_vec (valid_vec)
  );

  tlb_victim_pick #(
    .NUM_ENT (NUM_ENT)
  ) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (valid_vec),
    .install   (install),
    .victim    (victim)
  );

  tlb_table_walker #(
    .VPN_W  (VPN_W),
    .PFN_W  (PFN_W),
    .MEM_AW (MEM_AW),
    .MEM_DW (MEM_DW),
    .PRES_B (PRES_B)
  ) u_walker (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (walk_start),
    .vpn           (lk_vpn),
    .base          (pt_base),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .done          (walk_done),
    .present       (walk_present),
    .pfn           (walk_pfn)
  );

  // R5: the replayed lookup always finds the fresh entry
  assert_replay_hits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REPLAY) |-> hit);

  // R7: no new request is taken while a table read is pending
  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R6: a fault carries no address and follows a read
  assert_fault_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

  // R3: a lookup that hits in idle never starts a table read
  assert_hit_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> !mem_req_valid);
endmodule

// File: tb/tb_pid_xlat_cache.sv
module tb_pid_xlat_cache;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush_m, flush_r, flush;
  logic [31:0] pt_base;
  logic        req_valid, req_ready;
  logic [31:0] req_vaddr;
  logic [7:0]  req_pid;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_paddr;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  int n_chk = 0;
  int n_fail = 0;
  int reads = 0;
  int rdy_dly = 0;
  int lat = 0;
  bit flush_with_rsp = 1'b0;
  logic [31:0] last_addr;

  always #2 clk = ~clk;
  assign flush = flush_m | flush_r;

  pid_xlat_cache dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(pt_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_pid(req_pid), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // page table contents: not present when the page number ends in F
  function automatic logic [31:0] pte_of(input logic [31:0] a);
    logic [19:0] frame;
    frame = a[21:2] ^ {a[31:24], 12'h000} ^ 20'hA5A5A;
    if (a[5:2] == 4'hF) return {1'b0, 11'h7FF, frame};
    return {1'b1, 11'h7FF, frame};
  endfunction

  function automatic logic [19:0] exp_frame(input logic [19:0] vpn, input logic [7:0] pid);
    return vpn ^ {pid, 12'h000} ^ 20'hA5A5A;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory responder
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    flush_r       = 1'b0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        repeat (rdy_dly) @(negedge clk);
        mem_req_ready = 1'b1;
        last_addr = mem_req_addr;
        reads++;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (lat) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pte_of(last_addr);
        if (flush_with_rsp) flush_r = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        flush_r       = 1'b0;
      end
    end
  end

  task automatic do_req(input logic [19:0] vpn, input logic [7:0] pid,
                        input logic [11:0] off, input bit miss);
    int r0;
    int waited;
    bit saw_ready;
    bit fault;
    logic [31:0] exp_pa;
    fault  = miss && (vpn[3:0] == 4'hF);
    exp_pa = fault ? 32'h0 : {exp_frame(vpn, pid), off};
    @(negedge clk);
    pt_base   = {pid, 24'h0};
    req_vaddr = {vpn, off};
    req_pid   = pid;
    req_valid = 1'b1;
    r0 = reads;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    saw_ready = 1'b0;
    while (!rsp_valid && waited < 500) begin
      if (req_ready) saw_ready = 1'b1;
      @(negedge clk);
      waited++;
    end
    chk(rsp_valid, "R3 response seen", 64'(rsp_valid), 64'd1);
    chk((reads - r0) == int'(miss), miss ? "R4 one read on miss" : "R3 no read on hit",
        64'(reads - r0), 64'(miss));
    if (miss) begin
      chk(last_addr == {pid, 24'h0} + {10'h0, vpn, 2'b00}, "R4 table address",
          64'(last_addr), 64'({pid, 24'h0} + {10'h0, vpn, 2'b00}));
      chk(!saw_ready, "R7 ready low during refill", 64'(saw_ready), 64'd0);
      if (!fault)
        chk(waited == lat + rdy_dly + 3, "R5 replay timing", 64'(waited), 64'(lat + rdy_dly + 3));
    end else begin
      chk(waited == 0, "R3 hit latency", 64'(waited), 64'd0);
    end
    chk(rsp_fault == fault, "R6 fault flag", 64'(rsp_fault), 64'(fault));
    chk(rsp_paddr == exp_pa, "R2 physical address", 64'(rsp_paddr), 64'(exp_pa));
  endtask

  // {vpn, pid, offset, expect_miss}
  localparam logic [40:0] VEC [12] = '{
    {20'h00010, 8'h01, 12'h123, 1'b1},
    {20'h00010, 8'h01, 12'h456, 1'b0},
    {20'h00010, 8'h02, 12'h789, 1'b1},
    {20'h00010, 8'h02, 12'hABC, 1'b0},
    {20'h00010, 8'h01, 12'hFFF, 1'b0},
    {20'h00020, 8'h01, 12'h000, 1'b1},
    {20'h0001F, 8'h01, 12'hFFF, 1'b1},
    {20'h0001F, 8'h01, 12'h001, 1'b1},
    {20'h00020, 8'h01, 12'hFFF, 1'b0},
    {20'h00030, 8'h03, 12'h555, 1'b1},
    {20'h00010, 8'h01, 12'h321, 1'b0},
    {20'h00030, 8'h03, 12'h000, 1'b0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flush_m = 1'b0; pt_base = '0;
    req_valid = 1'b0; req_vaddr = '0; req_pid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", 64'(rsp_valid), 64'd0);
    chk(mem_req_valid == 1'b0, "R1 no read after reset", 64'(mem_req_valid), 64'd0);

    // table walk: R2 R3 R5 R6 R11 with varying memory latency
    for (int i = 0; i < 12; i++) begin
      rdy_dly = i % 3;
      lat     = (i * 5) % 7;
      do_req(VEC[i][40:21], VEC[i][20:13], VEC[i][12:1], VEC[i][0]);
    end

    // R8: flush blocks requests and drops everything
    @(negedge clk);
    flush_m = 1'b1;
    #1;
    chk(req_ready == 1'b0, "R8 ready low during flush", 64'(req_ready), 64'd0);
    @(negedge clk);
    flush_m = 1'b0;
    do_req(20'h00010, 8'h01, 12'h111, 1'b1);
    do_req(20'h00030, 8'h03, 12'h222, 1'b1);

    // R9: flush coincides with read data; entry still installed
    flush_with_rsp = 1'b1;
    rdy_dly = 1; lat = 2;
    do_req(20'h00020, 8'h01, 12'h333, 1'b1);
    flush_with_rsp = 1'b0;
    do_req(20'h00020, 8'h01, 12'h444, 1'b0);
    do_req(20'h00010, 8'h01, 12'h555, 1'b1);

    // R10: fill all slots, then round-robin evictions from slot 0
    @(negedge clk);
    flush_m = 1'b1;
    @(negedge clk);
    flush_m = 1'b0;
    rdy_dly = 0; lat = 1;
    for (int k = 0; k < 8; k++) do_req(20'h00100 + 20'(k), 8'h05, 12'h010, 1'b1);
    for (int k = 0; k < 8; k++) do_req(20'h00100 + 20'(k), 8'h05, 12'h020, 1'b0);
    do_req(20'h00108, 8'h05, 12'h030, 1'b1);
    do_req(20'h00101, 8'h05, 12'h040, 1'b0);
    do_req(20'h00100, 8'h05, 12'h050, 1'b1);
    do_req(20'h00101, 8'h05, 12'h060, 1'b1);
    do_req(20'h00108, 8'h05, 12'h070, 1'b0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule